// File: doc/BRIEF.md
# Tiled Strided Buffer Transfer Engine

This engine moves a two-dimensional tile out of global memory and into a core's scratchpad without using the compute pipeline. Software first loads a descriptor into one of four slots. The descriptor holds the global base address, the scratchpad base address, the tile height and width in elements, an element size code and the byte stride between tile rows in global memory. Software then sends a separate start command that names the slot. Loading a descriptor never starts any traffic.

A single address generator serves one slot at a time. It walks the global address and the scratchpad address together, one line-sized read request per step. Each accepted request takes a free entry in an eight-entry outstanding table, and that entry remembers where the line belongs in the scratchpad. The request carries the index of that entry as its tag. Fill responses may come back in any order. Each one is written straight to its recorded scratchpad address. When every fill of a slot has landed, the slot reports completion and becomes free again. An optional mode pads each scratchpad row with one unused element, which leaves a spare column.

Top module: `tile_xfer_engine`

## Requirements
- R1: A configure command (`cmd_start`=0) stores the descriptor of the named slot. It does not raise `req_valid` and does not set that slot's busy flag.
- R2: A start command (`cmd_start`=1) on an idle slot sets its busy flag on the next edge. Requests then follow, each covering `LINE_BYTES` (16) bytes. Within a tile row, each accepted request advances the global address and the scratchpad address by 16 together.
- R3: Element size is 2^`cmd_dtype` bytes (code 0=1, 1=2, 2=4 for single-precision float, 3=8). At the end of a row the global address moves to the row base plus the stride. The scratchpad address moves to the row base plus the row bytes (width × element size), plus one element when `cmd_blank`=1.
- R4: While `req_valid` is high and `req_ready` is low, `req_valid` and `req_gaddr` hold unchanged.
- R5: A response on a tag that has a request outstanding writes `rsp_data` to the scratchpad address recorded for that tag. The write appears on `sp_we`/`sp_addr`/`sp_wdata` in the cycle after the response. Responses may arrive in any order.
- R6: At most 8 requests are outstanding. `req_valid` stays low while 8 are outstanding.
- R7: One cycle after the last fill write of a slot, `done_valid` pulses for one cycle with `done_slot` set to that slot, and the slot's busy flag is low in that same cycle.
- R8: A start or configure command aimed at a busy slot is ignored and sets `err_sticky`, which stays high until reset. The slot's descriptor and its transfer are unchanged.
- R9: Slots waiting to run are served one at a time, lowest slot index first. The next slot's requests begin only after the current slot has issued its last request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_start | input | 1 | 1 = start slot, 0 = configure slot |
| cmd_slot | input | 2 | Target slot |
| cmd_gbase | input | 32 | Global base address |
| cmd_sbase | input | 16 | Scratchpad base address |
| cmd_rows | input | 8 | Tile height in rows (at least 1) |
| cmd_cols | input | 8 | Tile width in elements |
| cmd_dtype | input | 2 | Element size code |
| cmd_stride | input | 16 | Global row stride in bytes |
| cmd_blank | input | 1 | Pad one element per scratchpad row |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory side accepts the request |
| req_gaddr | output | 32 | Global line address |
| req_tag | output | 3 | Outstanding-table entry of the request |
| rsp_valid | input | 1 | Fill response valid |
| rsp_tag | input | 3 | Tag of the returning line |
| rsp_data | input | 128 | Line data |
| sp_we | output | 1 | Scratchpad write enable |
| sp_addr | output | 16 | Scratchpad byte address |
| sp_wdata | output | 128 | Scratchpad write data |
| done_valid | output | 1 | Slot completion pulse |
| done_slot | output | 2 | Slot that completed |
| slot_busy | output | 4 | Per-slot busy flags |
| err_sticky | output | 1 | Command to a busy slot was seen |

## Verification
Two events can land on the same clock edge. One is a response that frees an outstanding entry. The other is a request handshake that claims a different entry. The bench provokes this with random `req_ready` and responses chosen at random from the pending tags. It then checks that every scratchpad write carries the data for the address the scoreboard expects and that no more than eight requests are ever in flight. A second overlap is a start command arriving while an earlier slot is still draining its fills. The bench judges this by the order of the request stream and by the exact cycle of each completion pulse.

// File: rtl/tt_pkg.sv
package tt_pkg;

    typedef enum logic [1:0] {
        SL_IDLE  = 2'd0,
        SL_ARMED = 2'd1,
        SL_GEN   = 2'd2,
        SL_DRAIN = 2'd3
    } slot_state_e;

endpackage

// File: rtl/tt_desc_bank.sv
module tt_desc_bank
    import tt_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int GAW   = 32,
    parameter int SAW   = 16,
    parameter int DIMW  = 8,
    parameter int STRW  = 16,
    localparam int SLOTW = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_start,
    input  logic [SLOTW-1:0] cmd_slot,
    input  logic [GAW-1:0]   cmd_gbase,
    input  logic [SAW-1:0]   cmd_sbase,
    input  logic [DIMW-1:0]  cmd_rows,
    input  logic [DIMW-1:0]  cmd_cols,
    input  logic [1:0]       cmd_dtype,
    input  logic [STRW-1:0]  cmd_stride,
    input  logic             cmd_blank,
    input  logic             agen_idle,
    input  logic             gen_last,
    input  logic [NSLOT-1:0] fill_pending,
    output logic             launch,
    output logic [GAW-1:0]   l_gbase,
    output logic [SAW-1:0]   l_sbase,
    output logic [DIMW-1:0]  l_rows,
    output logic [DIMW-1:0]  l_cols,
    output logic [1:0]       l_dtype,
    output logic [STRW-1:0]  l_stride,
    output logic             l_blank,
    output logic [SLOTW-1:0] cur_slot,
    output logic [NSLOT-1:0] slot_busy,
    output logic             done_valid,
    output logic [SLOTW-1:0] done_slot,
    output logic             err
);

    typedef struct packed {
        logic [NSLOT-1:0][GAW-1:0]  gbase;
        logic [NSLOT-1:0][SAW-1:0]  sbase;
        logic [NSLOT-1:0][DIMW-1:0] rows;
        logic [NSLOT-1:0][DIMW-1:0] cols;
        logic [NSLOT-1:0][1:0]      dtype;
        logic [NSLOT-1:0][STRW-1:0] stride;
        logic [NSLOT-1:0]           blank;
        logic [NSLOT-1:0][1:0]      st;
        logic [SLOTW-1:0]           cur;
        logic                       done_v;
        logic [SLOTW-1:0]           done_s;
        logic                       err;
    } bank_t;

    bank_t q, d;
    logic             found;
    logic             finished;
    logic [SLOTW-1:0] pick;

    always_comb begin
        d        = q;
        d.done_v = 1'b0;
        found    = 1'b0;
        finished = 1'b0;
        pick     = '0;
        launch   = 1'b0;

        // retire one drained slot per cycle, lowest first
        for (int s = 0; s < NSLOT; s++) begin
            if (!finished && q.st[s] == SL_DRAIN && !fill_pending[s]) begin
                finished   = 1'b1;
                d.st[s]    = SL_IDLE;
                d.done_v   = 1'b1;
                d.done_s   = SLOTW'(s);
            end
        end

        if (gen_last) begin
            d.st[q.cur] = SL_DRAIN;
        end

        // lowest armed slot wins the generator
        for (int s = 0; s < NSLOT; s++) begin
            if (!found && q.st[s] == SL_ARMED) begin
                found = 1'b1;
                pick  = SLOTW'(s);
            end
        end
        if (agen_idle && found) begin
            launch     = 1'b1;
            d.st[pick] = SL_GEN;
            d.cur      = pick;
        end

        if (cmd_valid) begin
            if (q.st[cmd_slot] != SL_IDLE) begin
                d.err = 1'b1;
            end else if (cmd_start) begin
                d.st[cmd_slot] = SL_ARMED;
            end else begin
                d.gbase[cmd_slot]  = cmd_gbase;
                d.sbase[cmd_slot]  = cmd_sbase;
                d.rows[cmd_slot]   = cmd_rows;
                d.cols[cmd_slot]   = cmd_cols;
                d.dtype[cmd_slot]  = cmd_dtype;
                d.stride[cmd_slot] = cmd_stride;
                d.blank[cmd_slot]  = cmd_blank;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            slot_busy[s] = (q.st[s] != SL_IDLE);
        end
    end

    assign l_gbase    = q.gbase[pick];
    assign l_sbase    = q.sbase[pick];
    assign l_rows     = q.rows[pick];
    assign l_cols     = q.cols[pick];
    assign l_dtype    = q.dtype[pick];
    assign l_stride   = q.stride[pick];
    assign l_blank    = q.blank[pick];
    assign cur_slot   = q.cur;
    assign done_valid = q.done_v;
    assign done_slot  = q.done_s;
    assign err        = q.err;

    AST_BUSY_CMD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && slot_busy[cmd_slot] |=> err); // R8

    AST_DONE_AFTER_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !fill_pending[done_slot] && !slot_busy[done_slot]); // R7

endmodule

// File: rtl/tt_agen.sv
module tt_agen #(
    parameter int GAW        = 32,
    parameter int SAW        = 16,
    parameter int DIMW       = 8,
    parameter int STRW       = 16,
    parameter int LINE_BYTES = 16,
    localparam int RBW       = DIMW + 3,
    localparam int LSH       = $clog2(LINE_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  logic [GAW-1:0]  l_gbase,
    input  logic [SAW-1:0]  l_sbase,
    input  logic [DIMW-1:0] l_rows,
    input  logic [DIMW-1:0] l_cols,
    input  logic [1:0]      l_dtype,
    input  logic [STRW-1:0] l_stride,
    input  logic            l_blank,
    input  logic            hs,
    output logic            active,
    output logic [GAW-1:0]  gaddr,
    output logic [SAW-1:0]  saddr,
    output logic            gen_last
);

    typedef struct packed {
        logic            active;
        logic [GAW-1:0]  gcur;
        logic [SAW-1:0]  scur;
        logic [GAW-1:0]  grow;
        logic [SAW-1:0]  srow;
        logic [DIMW-1:0] row_i;
        logic [DIMW-1:0] rows;
        logic [RBW-1:0]  line_i;
        logic [RBW-1:0]  lpr;
        logic [SAW-1:0]  spitch;
        logic [STRW-1:0] stride;
    } agen_t;

    agen_t          q, d;
    logic [RBW-1:0] row_bytes;
    logic           line_end;
    logic           tile_end;

    assign row_bytes = RBW'(l_cols) << l_dtype;
    assign line_end  = (q.line_i == q.lpr - RBW'(1));
    assign tile_end  = line_end && (q.row_i == q.rows - DIMW'(1));
    assign gen_last  = hs && tile_end;

    always_comb begin
        d = q;
        if (launch) begin
            d.active = 1'b1;
            d.gcur   = l_gbase;
            d.grow   = l_gbase;
            d.scur   = l_sbase;
            d.srow   = l_sbase;
            d.row_i  = '0;
            d.rows   = l_rows;
            d.line_i = '0;
            d.lpr    = row_bytes >> LSH;
            d.spitch = SAW'(row_bytes) + (l_blank ? (SAW'(1) << l_dtype) : SAW'(0));
            d.stride = l_stride;
        end else if (hs) begin
            if (!line_end) begin
                d.line_i = q.line_i + RBW'(1);
                d.gcur   = q.gcur + GAW'(LINE_BYTES);
                d.scur   = q.scur + SAW'(LINE_BYTES);
            end else if (tile_end) begin
                d.active = 1'b0;
            end else begin
                d.line_i = '0;
                d.row_i  = q.row_i + DIMW'(1);
                d.grow   = q.grow + GAW'(q.stride);
                d.gcur   = q.grow + GAW'(q.stride);
                d.srow   = q.srow + q.spitch;
                d.scur   = q.srow + q.spitch;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign active = q.active;
    assign gaddr  = q.gcur;
    assign saddr  = q.scur;

    AST_LOCKSTEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        hs && !line_end |=> (gaddr == $past(gaddr) + GAW'(LINE_BYTES))
                         && (saddr == $past(saddr) + SAW'(LINE_BYTES))); // R2

endmodule

// File: rtl/tt_track.sv
module tt_track #(
    parameter int DEPTH = 8,
    parameter int SAW   = 16,
    parameter int NSLOT = 4,
    parameter int DATAW = 128,
    localparam int TAGW  = $clog2(DEPTH),
    localparam int SLOTW = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [SAW-1:0]   alloc_saddr,
    input  logic [SLOTW-1:0] alloc_slot,
    input  logic             rsp_valid,
    input  logic [TAGW-1:0]  rsp_tag,
    input  logic [DATAW-1:0] rsp_data,
    output logic             full,
    output logic [TAGW-1:0]  free_tag,
    output logic [NSLOT-1:0] fill_pending,
    output logic             sp_we,
    output logic [SAW-1:0]   sp_addr,
    output logic [DATAW-1:0] sp_wdata
);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][SAW-1:0]    saddr;
        logic [DEPTH-1:0][SLOTW-1:0]  slot;
        logic                         we;
        logic [SAW-1:0]               waddr;
        logic [DATAW-1:0]             wdata;
    } track_t;

    track_t q, d;

    always_comb begin
        free_tag = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!q.vld[i]) begin
                free_tag = TAGW'(i);
            end
        end
    end

    assign full = &q.vld;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (rsp_valid && q.vld[rsp_tag]) begin
            d.vld[rsp_tag] = 1'b0;
            d.we           = 1'b1;
            d.waddr        = q.saddr[rsp_tag];
            d.wdata        = rsp_data;
        end
        if (alloc) begin
            d.vld[free_tag]   = 1'b1;
            d.saddr[free_tag] = alloc_saddr;
            d.slot[free_tag]  = alloc_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        fill_pending = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (q.vld[i]) begin
                fill_pending[q.slot[i]] = 1'b1;
            end
        end
    end

    assign sp_we    = q.we;
    assign sp_addr  = q.waddr;
    assign sp_wdata = q.wdata;

    AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !(&q.vld)); // R6

    AST_FILL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && q.vld[rsp_tag] |=> sp_we && (sp_addr == $past(q.saddr[rsp_tag]))); // R5

endmodule

// File: rtl/tile_xfer_engine.sv
module tile_xfer_engine #(
    parameter int NSLOT      = 4,
    parameter int DEPTH      = 8,
    parameter int GAW        = 32,
    parameter int SAW        = 16,
    parameter int DIMW       = 8,
    parameter int STRW       = 16,
    parameter int LINE_BYTES = 16,
    localparam int SLOTW     = $clog2(NSLOT),
    localparam int TAGW      = $clog2(DEPTH),
    localparam int DATAW     = LINE_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_start,
    input  logic [SLOTW-1:0] cmd_slot,
    input  logic [GAW-1:0]   cmd_gbase,
    input  logic [SAW-1:0]   cmd_sbase,
    input  logic [DIMW-1:0]  cmd_rows,
    input  logic [DIMW-1:0]  cmd_cols,
    input  logic [1:0]       cmd_dtype,
    input  logic [STRW-1:0]  cmd_stride,
    input  logic             cmd_blank,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [GAW-1:0]   req_gaddr,
    output logic [TAGW-1:0]  req_tag,
    input  logic             rsp_valid,
    input  logic [TAGW-1:0]  rsp_tag,
    input  logic [DATAW-1:0] rsp_data,
    output logic             sp_we,
    output logic [SAW-1:0]   sp_addr,
    output logic [DATAW-1:0] sp_wdata,
    output logic             done_valid,
    output logic [SLOTW-1:0] done_slot,
    output logic [NSLOT-1:0] slot_busy,
    output logic             err_sticky
);

    logic             launch;
    logic [GAW-1:0]   l_gbase;
    logic [SAW-1:0]   l_sbase;
    logic [DIMW-1:0]  l_rows;
    logic [DIMW-1:0]  l_cols;
    logic [1:0]       l_dtype;
    logic [STRW-1:0]  l_stride;
    logic             l_blank;
    logic [SLOTW-1:0] cur_slot;
    logic [NSLOT-1:0] fill_pending;
    logic             agen_active;
    logic [SAW-1:0]   agen_saddr;
    logic             gen_last;
    logic             tbl_full;
    logic             hs;

    assign req_valid = agen_active && !tbl_full;
    assign hs        = req_valid && req_ready;

    tt_desc_bank #(
        .NSLOT(NSLOT), .GAW(GAW), .SAW(SAW), .DIMW(DIMW), .STRW(STRW)
    ) i_bank (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_slot(cmd_slot),
        .cmd_gbase(cmd_gbase), .cmd_sbase(cmd_sbase), .cmd_rows(cmd_rows),
        .cmd_cols(cmd_cols), .cmd_dtype(cmd_dtype), .cmd_stride(cmd_stride),
        .cmd_blank(cmd_blank),
        .agen_idle(!agen_active), .gen_last(gen_last), .fill_pending(fill_pending),
        .launch(launch), .l_gbase(l_gbase), .l_sbase(l_sbase), .l_rows(l_rows),
        .l_cols(l_cols), .l_dtype(l_dtype), .l_stride(l_stride), .l_blank(l_blank),
        .cur_slot(cur_slot), .slot_busy(slot_busy),
        .done_valid(done_valid), .done_slot(done_slot), .err(err_sticky)
    );

    tt_agen #(
        .GAW(GAW), .SAW(SAW), .DIMW(DIMW), .STRW(STRW), .LINE_BYTES(LINE_BYTES)
    ) i_agen (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .l_gbase(l_gbase), .l_sbase(l_sbase), .l_rows(l_rows), .l_cols(l_cols),
        .l_dtype(l_dtype), .l_stride(l_stride), .l_blank(l_blank),
        .hs(hs), .active(agen_active), .gaddr(req_gaddr), .saddr(agen_saddr),
        .gen_last(gen_last)
    );

    tt_track #(
        .DEPTH(DEPTH), .SAW(SAW), .NSLOT(NSLOT), .DATAW(DATAW)
    ) i_track (
        .clk(clk), .rst_n(rst_n),
        .alloc(hs), .alloc_saddr(agen_saddr), .alloc_slot(cur_slot),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .full(tbl_full), .free_tag(req_tag), .fill_pending(fill_pending),
        .sp_we(sp_we), .sp_addr(sp_addr), .sp_wdata(sp_wdata)
    );

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_gaddr)); // R4

endmodule

// File: tb/test_tile_xfer_engine.sv
module test_tile_xfer_engine;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_start = 1'b0;
    logic [1:0]   cmd_slot = '0;
    logic [31:0]  cmd_gbase = '0;
    logic [15:0]  cmd_sbase = '0;
    logic [7:0]   cmd_rows = '0;
    logic [7:0]   cmd_cols = '0;
    logic [1:0]   cmd_dtype = '0;
    logic [15:0]  cmd_stride = '0;
    logic         cmd_blank = 1'b0;
    logic         req_valid;
    logic         req_ready = 1'b0;
    logic [31:0]  req_gaddr;
    logic [2:0]   req_tag;
    logic         rsp_valid = 1'b0;
    logic [2:0]   rsp_tag = '0;
    logic [127:0] rsp_data = '0;
    logic         sp_we;
    logic [15:0]  sp_addr;
    logic [127:0] sp_wdata;
    logic         done_valid;
    logic [1:0]   done_slot;
    logic [3:0]   slot_busy;
    logic         err_sticky;

    always #2 clk = ~clk;

    tile_xfer_engine i_tile_xfer_engine (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_slot(cmd_slot),
        .cmd_gbase(cmd_gbase), .cmd_sbase(cmd_sbase), .cmd_rows(cmd_rows),
        .cmd_cols(cmd_cols), .cmd_dtype(cmd_dtype), .cmd_stride(cmd_stride),
        .cmd_blank(cmd_blank),
        .req_valid(req_valid), .req_ready(req_ready), .req_gaddr(req_gaddr),
        .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .sp_we(sp_we), .sp_addr(sp_addr), .sp_wdata(sp_wdata),
        .done_valid(done_valid), .done_slot(done_slot),
        .slot_busy(slot_busy), .err_sticky(err_sticky)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] fdata(input logic [31:0] g);
        return {g, ~g, g ^ 32'h5A5A_C3C3, g + 32'h1111_0000};
    endfunction

    // bench shadow of descriptors
    logic [31:0] sh_g [4];
    logic [15:0] sh_s [4];
    int          sh_rows [4];
    int          sh_cols [4];
    int          sh_dt [4];
    int          sh_str [4];
    bit          sh_blank [4];

    // scoreboard
    logic [31:0]  exp_req_q [$];
    logic [127:0] exp_sp_data [logic [15:0]];
    int           exp_sp_slot [logic [15:0]];
    int           left [4];
    logic [2:0]   pend_tag [$];
    logic [31:0]  pend_g [$];

    int ready_mode = 0;   // 0 low, 1 high, 2 random
    int rsp_mode   = 0;   // 0 none, 1 oldest, 2 random any
    bit done_due = 1'b0;
    int due_slot = 0;
    bit stall_prev = 1'b0;
    logic [31:0] stall_g = '0;

    task automatic plan(input int slot);
        int eb, rb, lpr, pitch;
        logic [31:0] g;
        logic [15:0] s;
        eb = 1 << sh_dt[slot];
        rb = sh_cols[slot] * eb;
        lpr = rb / 16;
        pitch = rb + (sh_blank[slot] ? eb : 0);
        for (int r = 0; r < sh_rows[slot]; r++) begin
            for (int l = 0; l < lpr; l++) begin
                g = sh_g[slot] + 32'(r * sh_str[slot]) + 32'(l * 16);
                s = sh_s[slot] + 16'(r * pitch) + 16'(l * 16);
                exp_req_q.push_back(g);
                exp_sp_data[s] = fdata(g);
                exp_sp_slot[s] = slot;
                left[slot]++;
            end
        end
    endtask

    task automatic cfg(input int slot, input logic [31:0] g, input logic [15:0] s,
                       input int rows, input int cols, input int dt, input int str,
                       input bit blank, input bit take);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_start = 1'b0; cmd_slot = 2'(slot);
        cmd_gbase = g; cmd_sbase = s; cmd_rows = 8'(rows); cmd_cols = 8'(cols);
        cmd_dtype = 2'(dt); cmd_stride = 16'(str); cmd_blank = blank;
        if (take) begin
            sh_g[slot] = g; sh_s[slot] = s; sh_rows[slot] = rows; sh_cols[slot] = cols;
            sh_dt[slot] = dt; sh_str[slot] = str; sh_blank[slot] = blank;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic start(input int slot);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_start = 1'b1; cmd_slot = 2'(slot);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_start = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        bit ok;
        ok = 1'b0;
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            if (exp_req_q.size() == 0 && left[0] == 0 && left[1] == 0 &&
                left[2] == 0 && left[3] == 0 && slot_busy == 4'b0) begin
                ok = 1'b1;
                break;
            end
        end
        chk(ok, {tag, " transfer drained"}, 64'(exp_req_q.size()), 64'd0);
        repeat (2) @(negedge clk);
    endtask

    // memory model and monitors
    always @(negedge clk) begin
        bit nr;
        int idx;
        if (rst_n) begin
            // R7: completion pulse exactly one cycle after the last write
            if (done_due) begin
                chk(done_valid && done_slot == 2'(due_slot), "R7 done pulse",
                    {62'd0, done_slot}, 64'(due_slot));
                chk(!slot_busy[due_slot], "R7 busy cleared", 64'(slot_busy), 64'd0);
                done_due = 1'b0;
            end else if (done_valid) begin
                chk(1'b0, "R7 unexpected done", {62'd0, done_slot}, 64'd0);
            end
            // R5: scratchpad writes land on the recorded addresses
            if (sp_we) begin
                if (exp_sp_data.exists(sp_addr)) begin
                    chk(sp_wdata == exp_sp_data[sp_addr], "R5 fill data",
                        sp_wdata[63:0], exp_sp_data[sp_addr][63:0]);
                    idx = exp_sp_slot[sp_addr];
                    left[idx]--;
                    if (left[idx] == 0) begin
                        done_due = 1'b1;
                        due_slot = idx;
                    end
                    exp_sp_data.delete(sp_addr);
                    exp_sp_slot.delete(sp_addr);
                end else begin
                    chk(1'b0, "R3 unexpected scratchpad address", 64'(sp_addr), 64'd0);
                end
            end
            // R4: stalled request holds
            if (stall_prev) begin
                chk(req_valid && req_gaddr == stall_g, "R4 request held",
                    64'(req_gaddr), 64'(stall_g));
            end
            // R6: bound on outstanding requests
            if (pend_tag.size() >= 8) begin
                chk(!req_valid && pend_tag.size() == 8, "R6 outstanding bound",
                    64'(pend_tag.size()), 64'd8);
            end
            // responses (chosen before this cycle's request is recorded)
            rsp_valid = 1'b0;
            if (rsp_mode != 0 && pend_tag.size() > 0 &&
                (rsp_mode == 1 || ($urandom % 3) == 0)) begin
                idx = (rsp_mode == 1) ? 0 : int'($urandom % pend_tag.size());
                rsp_valid = 1'b1;
                rsp_tag   = pend_tag[idx];
                rsp_data  = fdata(pend_g[idx]);
                pend_tag.delete(idx);
                pend_g.delete(idx);
            end
            // request side
            nr = (ready_mode == 1) || (ready_mode == 2 && ($urandom % 2) == 0);
            if (req_valid && nr) begin
                if (exp_req_q.size() > 0) begin
                    chk(req_gaddr == exp_req_q[0], "R2/R3 request address",
                        64'(req_gaddr), 64'(exp_req_q[0]));
                    void'(exp_req_q.pop_front());
                end else begin
                    chk(1'b0, "R1 unexpected request", 64'(req_gaddr), 64'd0);
                end
                pend_tag.push_back(req_tag);
                pend_g.push_back(req_gaddr);
            end
            stall_prev = req_valid && !nr;
            stall_g    = req_gaddr;
            req_ready  = nr;
        end
    end

    // watchdog
    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++) left[s] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(!req_valid && !sp_we && !done_valid, "R1 reset outputs idle",
            {61'd0, req_valid, sp_we, done_valid}, 64'd0);
        chk(slot_busy == 4'b0 && !err_sticky, "R8 reset flags clear",
            {59'd0, slot_busy, err_sticky}, 64'd0);

        // R1: configure alone starts nothing
        ready_mode = 1; rsp_mode = 1;
        cfg(0, 32'h0000_1020, 16'h0020, 3, 8, 2, 32'h100, 1'b0, 1'b1);
        repeat (6) @(negedge clk);
        chk(!req_valid && slot_busy == 4'b0, "R1 configure does not launch",
            {59'd0, slot_busy, req_valid}, 64'd0);

        // R2/R3/R5/R7: float tile, no padding, in-order memory
        plan(0);
        start(0);
        chk(slot_busy[0], "R2 busy after start", 64'(slot_busy), 64'd1);
        wait_idle("R2");

        // R3: 2-byte elements with padding, random handshake and out-of-order fills
        ready_mode = 2; rsp_mode = 2;
        cfg(1, 32'h0000_8000, 16'h0400, 4, 16, 1, 32'h40, 1'b1, 1'b1);
        plan(1); start(1); wait_idle("R3 dtype1 blank");
        cfg(2, 32'h0002_0000, 16'h0800, 5, 2, 3, 32'h200, 1'b1, 1'b1);
        plan(2); start(2); wait_idle("R3 dtype3 blank");
        cfg(3, 32'h0003_0000, 16'h0C00, 2, 32, 0, 32'h300, 1'b1, 1'b1);
        plan(3); start(3); wait_idle("R3 dtype0 odd pitch");

        // R8: commands to a busy slot are ignored and flagged
        ready_mode = 0; rsp_mode = 1;
        cfg(0, 32'h0000_3000, 16'h1000, 2, 4, 2, 32'h80, 1'b0, 1'b1);
        plan(0); start(0);
        chk(!err_sticky, "R8 no error on idle start", 64'(err_sticky), 64'd0);
        start(0);
        chk(err_sticky, "R8 start to busy slot flags error", 64'(err_sticky), 64'd1);
        cfg(0, 32'h9999_0000, 16'h7000, 1, 4, 2, 32'h10, 1'b0, 1'b0);
        ready_mode = 1;
        wait_idle("R8 old descriptor kept");
        plan(0); start(0); wait_idle("R8 descriptor unchanged");
        chk(err_sticky, "R8 error sticky", 64'(err_sticky), 64'd1);

        // R9: lowest armed slot served first
        ready_mode = 0; rsp_mode = 2;
        cfg(1, 32'h0001_1000, 16'h2000, 2, 8, 2, 32'h100, 1'b0, 1'b1);
        cfg(2, 32'h0002_2000, 16'h2400, 2, 8, 2, 32'h100, 1'b0, 1'b1);
        cfg(3, 32'h0003_3000, 16'h2800, 2, 8, 2, 32'h100, 1'b0, 1'b1);
        start(3); start(2); start(1);
        plan(3); plan(1); plan(2);
        chk(slot_busy == 4'b1110, "R9 three slots busy", 64'(slot_busy), 64'hE);
        ready_mode = 2;
        wait_idle("R9 order");

        // R6: table fills and stalls requests
        ready_mode = 1; rsp_mode = 0;
        cfg(0, 32'h0005_0000, 16'h3000, 6, 8, 2, 32'h100, 1'b0, 1'b1);
        plan(0); start(0);
        repeat (20) @(negedge clk);
        chk(pend_tag.size() == 8 && !req_valid, "R6 stalled at eight",
            64'(pend_tag.size()), 64'd8);
        rsp_mode = 2;
        wait_idle("R6 release");

        // mixed stress
        ready_mode = 2; rsp_mode = 2;
        for (int i = 0; i < 8; i++) begin
            int dt;
            dt = i % 4;
            cfg(i % 4, 32'h0010_0000 * (i + 1), 16'h4000 + 16'(i * 16'h400),
                2 + i % 3, (32 >> dt) * ((i % 2) + 1), dt, 32'h400, i[0], 1'b1);
            plan(i % 4); start(i % 4); wait_idle("R5 stress");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule